// File: doc/BRIEF.md
# Contention Busy Arbiter

This block arbitrates between two ports that may reach the same shared memory location at the same time. Each port presents a select and an address. When both selects are active and the addresses are equal, the arbiter picks one port as the owner of the location and raises a busy flag toward the other one after a configurable number of cycles. A port counts as having started earlier when its access began more than a set number of cycles before the other port's access. If the two starts fall inside that window, the left port is chosen.

A mode strap selects between two roles. As master, the block compares addresses itself and drives its busy outputs with the result. As slave, it does no comparing. It takes busy from a master's busy outputs on two input pins, so that several devices can share one decision when they are placed side by side for a wider word. A write-inhibit output per port tells the data path when that port must not write. In master mode it follows the port's busy. In slave mode it stays high from the start of an access until the incoming busy has been low for a set number of cycles.

An access *starts* at a clock edge where the port's select is sampled active and, at the previous edge, either the select was inactive or the address was different. Every output is a register, so inputs sampled at edge N show up on the outputs just after edge N.

Top module: `contention_busy`

## Requirements
- R1: In master mode (`master_i`=1) a busy output is high after edge N only if, at some edge, both selects were active and the two addresses were equal. A busy output that is high after edge N always traces back to such a match that is still being sampled.
- R2: When the two starts of a matching pair are more than `WIN_CYC` cycles apart, the port that started first wins and busy goes to the other port.
- R3: When the two starts are `WIN_CYC` cycles apart or closer, the left port wins. In master mode both busy outputs are never high together.
- R4: If the first edge that samples a match is edge N, the loser's busy is low after edges N to N+`BUSY_DLY`-1 and high after edge N+`BUSY_DLY`. It stays high while the match holds.
- R5: Busy drops after the first edge that no longer samples a match, for example when the winner releases its select or moves its address. A new start on either port while the match holds triggers a fresh arbitration.
- R6: In slave mode (`master_i`=0) each busy output, after edge N, equals the matching busy input sampled at edge N.
- R7: In slave mode a port's write inhibit is low while its select is inactive. While the select is active, the inhibit is high until the busy input has been sampled low on `SETTLE_CYC` consecutive edges, counted from the access start. Any edge that samples busy high restarts the count.
- R8: In master mode each write-inhibit output equals that port's busy output.
- R9: During reset and just after it, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | Role strap: 1 = master (compare and drive busy), 0 = slave (take busy from the inputs) |
| cs_l_i | input | 1 | Left port select, active high |
| addr_l_i | input | ADDR_W | Left port address |
| cs_r_i | input | 1 | Right port select, active high |
| addr_r_i | input | ADDR_W | Right port address |
| busy_in_l_i | input | 1 | Busy for the left port, coming from a master (used in slave mode) |
| busy_in_r_i | input | 1 | Busy for the right port, coming from a master (used in slave mode) |
| busy_l_o | output | 1 | Busy toward the left port |
| busy_r_o | output | 1 | Busy toward the right port |
| wr_inh_l_o | output | 1 | Left port write inhibit |
| wr_inh_r_o | output | 1 | Right port write inhibit |

## Verification
The hardest condition to create from the ports is a match whose two starts lie exactly on the edges of the window. That means gaps of `WIN_CYC` and `WIN_CYC`+1 cycles in each direction, combined with the exact cycle on which busy first rises. The stimulus sweeps the signed gap between the two select rises over every value from well before the window to well after it, and compares every output on every cycle against a timestamp model. A second situation is a re-arbitration while the match still holds. It is reached by moving the winner's address away and back again, which makes the winner the later starter. Slave mode is driven through every 8-bit pattern of busy and select activity, so that runs of low busy end exactly at the settle length and also one cycle short of it.

// File: rtl/contention_busy_pkg.sv
package contention_busy_pkg;

    typedef enum logic {
        SIDE_L = 1'b0,
        SIDE_R = 1'b1
    } side_e;

endpackage

// File: rtl/contention_busy_track.sv
module contention_busy_track #(
    parameter int ADDR_W     = 6,
    parameter int AGE_MAX    = 3,
    parameter int AGE_W      = 2,
    parameter int SETTLE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              busy_i,
    output logic              start_o,
    output logic [AGE_W-1:0]  age_o,
    output logic              settled_o
);

    localparam int SET_W = $clog2(SETTLE_CYC + 1);

    typedef struct packed {
        logic              cs;
        logic [ADDR_W-1:0] addr;
        logic [AGE_W-1:0]  age;
        logic [SET_W-1:0]  settle;
    } trk_t;

    trk_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        start_o = cs_i && (!st_q.cs || (addr_i != st_q.addr));

        if (!cs_i || start_o) begin
            age_o = '0;
        end else if (st_q.age == AGE_W'(AGE_MAX)) begin
            age_o = st_q.age;
        end else begin
            age_o = st_q.age + 1'b1;
        end

        st_d.cs   = cs_i;
        st_d.addr = addr_i;
        st_d.age  = age_o;

        if (busy_i || !cs_i || start_o) begin
            st_d.settle = '0;
        end else if (st_q.settle != SET_W'(SETTLE_CYC)) begin
            st_d.settle = st_q.settle + 1'b1;
        end

        settled_o = (st_d.settle == SET_W'(SETTLE_CYC));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/contention_busy_core.sv
module contention_busy_core
    import contention_busy_pkg::*;
#(
    parameter int AGE_W    = 2,
    parameter int WIN_CYC  = 2,
    parameter int BUSY_DLY = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             master_i,
    input  logic             match_i,
    input  logic             start_l_i,
    input  logic             start_r_i,
    input  logic [AGE_W-1:0] age_l_i,
    input  logic [AGE_W-1:0] age_r_i,
    input  logic             cs_l_i,
    input  logic             cs_r_i,
    input  logic             settled_l_i,
    input  logic             settled_r_i,
    input  logic             busy_in_l_i,
    input  logic             busy_in_r_i,
    output logic             busy_l_o,
    output logic             busy_r_o,
    output logic             inh_l_o,
    output logic             inh_r_o
);

    localparam int CNT_W = (BUSY_DLY > 0) ? $clog2(BUSY_DLY + 1) : 1;

    typedef struct packed {
        logic             lock;
        side_e            win;
        logic [CNT_W-1:0] cnt;
        logic             busy_l;
        logic             busy_r;
        logic             inh_l;
        logic             inh_r;
    } arb_t;

    arb_t st_d, st_q;
    logic arb_new;
    logic loser_busy;

    always_comb begin
        st_d       = st_q;
        arb_new    = match_i && (!st_q.lock || start_l_i || start_r_i);
        loser_busy = 1'b0;

        if (!master_i) begin
            st_d.lock   = 1'b0;
            st_d.cnt    = '0;
            st_d.busy_l = busy_in_l_i;
            st_d.busy_r = busy_in_r_i;
            st_d.inh_l  = cs_l_i && !settled_l_i;
            st_d.inh_r  = cs_r_i && !settled_r_i;
        end else begin
            if (!match_i) begin
                st_d.lock = 1'b0;
                st_d.cnt  = '0;
            end else if (arb_new) begin
                st_d.lock = 1'b1;
                st_d.cnt  = '0;
                if (int'(age_r_i) > int'(age_l_i) + WIN_CYC) begin
                    st_d.win = SIDE_R;
                end else begin
                    st_d.win = SIDE_L;
                end
            end else if (st_q.cnt != CNT_W'(BUSY_DLY)) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end

            loser_busy  = st_d.lock && (st_d.cnt == CNT_W'(BUSY_DLY));
            st_d.busy_l = loser_busy && (st_d.win == SIDE_R);
            st_d.busy_r = loser_busy && (st_d.win == SIDE_L);
            st_d.inh_l  = st_d.busy_l;
            st_d.inh_r  = st_d.busy_r;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{lock: 1'b0, win: SIDE_L, cnt: '0,
                      busy_l: 1'b0, busy_r: 1'b0, inh_l: 1'b0, inh_r: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_l_o = st_q.busy_l;
    assign busy_r_o = st_q.busy_r;
    assign inh_l_o  = st_q.inh_l;
    assign inh_r_o  = st_q.inh_r;

endmodule

// File: rtl/contention_busy.sv
module contention_busy #(
    parameter int ADDR_W     = 6,
    parameter int WIN_CYC    = 2,
    parameter int BUSY_DLY   = 1,
    parameter int SETTLE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_i,
    input  logic              cs_l_i,
    input  logic [ADDR_W-1:0] addr_l_i,
    input  logic              cs_r_i,
    input  logic [ADDR_W-1:0] addr_r_i,
    input  logic              busy_in_l_i,
    input  logic              busy_in_r_i,
    output logic              busy_l_o,
    output logic              busy_r_o,
    output logic              wr_inh_l_o,
    output logic              wr_inh_r_o
);

    localparam int AGE_MAX = WIN_CYC + 1;
    localparam int AGE_W   = $clog2(AGE_MAX + 1);
    localparam int NPORT   = 2;

    logic [NPORT-1:0]  cs_v;
    logic [NPORT-1:0]  bin_v;
    logic [NPORT-1:0]  start_v;
    logic [NPORT-1:0]  settled_v;
    logic [ADDR_W-1:0] addr_v [NPORT];
    logic [AGE_W-1:0]  age_v  [NPORT];
    logic              match;

    assign cs_v      = {cs_r_i, cs_l_i};
    assign bin_v     = {busy_in_r_i, busy_in_l_i};
    assign addr_v[0] = addr_l_i;
    assign addr_v[1] = addr_r_i;

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        contention_busy_track #(
            .ADDR_W     (ADDR_W),
            .AGE_MAX    (AGE_MAX),
            .AGE_W      (AGE_W),
            .SETTLE_CYC (SETTLE_CYC)
        ) u_track (
            .clk       (clk),
            .rst_n     (rst_n),
            .cs_i      (cs_v[g]),
            .addr_i    (addr_v[g]),
            .busy_i    (bin_v[g]),
            .start_o   (start_v[g]),
            .age_o     (age_v[g]),
            .settled_o (settled_v[g])
        );
    end

    assign match = master_i && cs_l_i && cs_r_i && (addr_l_i == addr_r_i);

    contention_busy_core #(
        .AGE_W    (AGE_W),
        .WIN_CYC  (WIN_CYC),
        .BUSY_DLY (BUSY_DLY)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .master_i    (master_i),
        .match_i     (match),
        .start_l_i   (start_v[0]),
        .start_r_i   (start_v[1]),
        .age_l_i     (age_v[0]),
        .age_r_i     (age_v[1]),
        .cs_l_i      (cs_l_i),
        .cs_r_i      (cs_r_i),
        .settled_l_i (settled_v[0]),
        .settled_r_i (settled_v[1]),
        .busy_in_l_i (busy_in_l_i),
        .busy_in_r_i (busy_in_r_i),
        .busy_l_o    (busy_l_o),
        .busy_r_o    (busy_r_o),
        .inh_l_o     (wr_inh_l_o),
        .inh_r_o     (wr_inh_r_o)
    );

endmodule

// File: rtl/contention_busy_chk.sv
module contention_busy_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              master_i,
    input logic              cs_l_i,
    input logic [ADDR_W-1:0] addr_l_i,
    input logic              cs_r_i,
    input logic [ADDR_W-1:0] addr_r_i,
    input logic              busy_in_l_i,
    input logic              busy_in_r_i,
    input logic              busy_l_o,
    input logic              busy_r_o,
    input logic              wr_inh_l_o,
    input logic              wr_inh_r_o
);

    logic same;
    assign same = cs_l_i && cs_r_i && (addr_l_i == addr_r_i);

    p_busy_needs_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((busy_l_o || busy_r_o) && $past(master_i)) |-> $past(master_i && same));

    p_single_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(master_i) |-> !(busy_l_o && busy_r_o));

    p_drop_l_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (master_i && busy_l_o && !same) |=> !busy_l_o);

    p_drop_r_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (master_i && busy_r_o && !same) |=> !busy_r_o);

    p_follow_l_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !master_i |=> (busy_l_o == $past(busy_in_l_i)));

    p_follow_r_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !master_i |=> (busy_r_o == $past(busy_in_r_i)));

    p_slave_inh_l_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_i && cs_l_i && busy_in_l_i) |=> wr_inh_l_o);

    p_slave_inh_r_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_i && cs_r_i && busy_in_r_i) |=> wr_inh_r_o);

    p_master_inh_r8: assert property (@(posedge clk) disable iff (!rst_n)
        master_i |=> ((wr_inh_l_o == busy_l_o) && (wr_inh_r_o == busy_r_o)));

endmodule

bind contention_busy contention_busy_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_i    (master_i),
    .cs_l_i      (cs_l_i),
    .addr_l_i    (addr_l_i),
    .cs_r_i      (cs_r_i),
    .addr_r_i    (addr_r_i),
    .busy_in_l_i (busy_in_l_i),
    .busy_in_r_i (busy_in_r_i),
    .busy_l_o    (busy_l_o),
    .busy_r_o    (busy_r_o),
    .wr_inh_l_o  (wr_inh_l_o),
    .wr_inh_r_o  (wr_inh_r_o)
);

// File: tb/contention_busy_bench.sv
`timescale 1ns/1ps
module contention_busy_bench;

    localparam int AW  = 3;
    localparam int WIN = 2;
    localparam int DLY = 2;
    localparam int SET = 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n  = 1'b0;
    logic          master = 1'b1;
    logic          cs_l   = 1'b0;
    logic          cs_r   = 1'b0;
    logic          bl     = 1'b0;
    logic          br     = 1'b0;
    logic [AW-1:0] al     = '0;
    logic [AW-1:0] ar     = '0;
    logic          o_bl, o_br, o_il, o_ir;

    contention_busy #(
        .ADDR_W(AW), .WIN_CYC(WIN), .BUSY_DLY(DLY), .SETTLE_CYC(SET)
    ) u_contention_busy (
        .clk(clk), .rst_n(rst_n), .master_i(master),
        .cs_l_i(cs_l), .addr_l_i(al), .cs_r_i(cs_r), .addr_r_i(ar),
        .busy_in_l_i(bl), .busy_in_r_i(br),
        .busy_l_o(o_bl), .busy_r_o(o_br), .wr_inh_l_o(o_il), .wr_inh_r_o(o_ir)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string tag   = "R9";

    // timestamp reference model
    int            cyc = 0, ts_l = 0, ts_r = 0, run_l = 0, run_r = 0, since = 0;
    bit            pcs_l = 0, pcs_r = 0, lock = 0, win_r = 0;
    logic [AW-1:0] pa_l = '0, pa_r = '0;
    bit            e_bl = 0, e_br = 0, e_il = 0, e_ir = 0;
    bit            st_l, st_r, m;

    always @(posedge clk) begin
        if (!rst_n) begin
            pcs_l = 0; pcs_r = 0; lock = 0; run_l = 0; run_r = 0;
            e_bl = 0; e_br = 0; e_il = 0; e_ir = 0;
        end else begin
            cyc++;
            st_l = cs_l && (!pcs_l || al != pa_l);
            st_r = cs_r && (!pcs_r || ar != pa_r);
            if (st_l) ts_l = cyc;
            if (st_r) ts_r = cyc;
            run_l = (bl || !cs_l || st_l) ? 0 : run_l + 1;
            run_r = (br || !cs_r || st_r) ? 0 : run_r + 1;
            pcs_l = cs_l; pcs_r = cs_r; pa_l = al; pa_r = ar;
            m = master && cs_l && cs_r && (al == ar);
            if (!master) begin
                lock = 0;
                e_bl = bl; e_br = br;
                e_il = cs_l && (run_l < SET);
                e_ir = cs_r && (run_r < SET);
            end else begin
                if (!m) lock = 0;
                else if (!lock || st_l || st_r) begin
                    lock = 1; since = 0; win_r = ((ts_l - ts_r) > WIN);
                end else since++;
                e_bl = lock && (since >= DLY) && win_r;
                e_br = lock && (since >= DLY) && !win_r;
                e_il = e_bl; e_ir = e_br;
            end
        end
    end

    task automatic chk(input string t, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: actual %b expected %b", t, what, cyc, act, exp);
        end
    endtask

    task automatic tick();
        string ti;
        @(posedge clk);
        #1;
        ti = master ? "R8" : tag;
        chk(tag, "busy_l", o_bl, e_bl);
        chk(tag, "busy_r", o_br, e_br);
        chk(ti, "wr_inh_l", o_il, e_il);
        chk(ti, "wr_inh_r", o_ir, e_ir);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog (all requirements): actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        // R9: outputs low in and just after reset
        tag = "R9";
        for (int k = 0; k < 3; k++) tick();
        rst_n = 1'b1;
        tick();

        // R2 R3 R4: sweep of the signed start gap, every cycle compared
        tag = "R2 R3 R4";
        for (int d = -(WIN + 3); d <= WIN + 3; d++) begin
            int ls, rs;
            ls = 1 + ((d < 0) ? -d : 0);
            rs = ls + d;
            al = AW'(d + 8); ar = AW'(d + 8);
            for (int k = 0; k < 18; k++) begin
                cs_l = (k >= ls) && (k < 15);
                cs_r = (k >= rs) && (k < 15);
                tick();
            end
        end

        // R1: every address pair, busy only for equal addresses
        tag = "R1";
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                al = AW'(a); ar = AW'(b);
                cs_l = 1'b1; cs_r = 1'b1;
                for (int k = 0; k < 4; k++) tick();
                cs_r = 1'b0;
                tick();
                cs_l = 1'b0;
                tick();
            end
        end

        // R5: winner moves away, comes back and re-arbitration flips the winner
        tag = "R5";
        al = 3'd5; ar = 3'd5; cs_l = 1'b1;
        for (int k = 0; k < 5; k++) tick();
        cs_r = 1'b1;
        for (int k = 0; k < 5; k++) tick();
        al = 3'd2;
        for (int k = 0; k < 3; k++) tick();
        al = 3'd5;
        for (int k = 0; k < 5; k++) tick();
        cs_r = 1'b0;
        for (int k = 0; k < 3; k++) tick();
        cs_l = 1'b0;
        tick();

        // R6 R7: slave mode, all 8-bit activity patterns
        tag = "R6 R7";
        master = 1'b0;
        tick();
        for (int p = 0; p < 256; p++) begin
            for (int k = 0; k < 6; k++) begin
                cs_l = p[7] ? 1'b1 : (k > 0);
                cs_r = p[6] ? (k < 4) : 1'b1;
                bl   = p[k];
                br   = p[5 - k];
                if (k == 3 && p[7] && p[6]) al = al + 1'b1;
                tick();
            end
        end
        cs_l = 1'b0; cs_r = 1'b0; bl = 1'b0; br = 1'b0;
        tick();
        master = 1'b1;
        tick();

        // R1 R2 R3 R5: pseudo-random master traffic on a two-address space
        tag = "R1 R2 R3 R5";
        lfsr = 16'hACE1;
        for (int k = 0; k < 3000; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[5:4] == 2'b00) begin
                cs_l = lfsr[0] | lfsr[1];
                cs_r = lfsr[2] | lfsr[3];
                al   = AW'(lfsr[6]);
                ar   = AW'(lfsr[7]);
            end
            tick();
        end

        done = 1;
        summary();
        $finish;
    end

endmodule